// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. On every operation it takes an operation code, the accumulator, one operand, a pair of 16-bit register values and the current four condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). From these it returns an 8-bit result with its write enable, a 16-bit result with its own write enable, and a new flag byte. The unit holds no state. Operand fetch, the register file and instruction sequencing all live outside it.

The 8-bit side covers add, add with carry, subtract, subtract with borrow, compare, the three bitwise operations, increment, decrement, complement, set carry, complement carry and the decimal adjust for packed BCD. The 16-bit side covers a register-pair add, a stack-pointer add with a signed 8-bit offset, and 16-bit increment and decrement. The half-carry rule changes with the operation: a nibble carry for byte adds, a carry out of bit 11 for pair adds, and low-byte-only flags for the signed stack-pointer add.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry-in C) write acc+opd(+C) to the 8-bit result. Z is set when the byte is zero, N is 0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R2: Op 2 (subtract) and op 3 (subtract with borrow C) write acc-opd(-C). Z follows the byte, N is 1, H is the borrow out of the low nibble, and C is set when opd (plus C for op 3) exceeds acc.
- R3: Op 4 (compare) sets the flags exactly as op 2 does. It does not write: the result write enable is 0 and the 8-bit result equals acc.
- R4: Op 5 (AND) gives H=1. Op 6 (OR) and op 7 (XOR) give H=0. All three write the bitwise result, set N=0 and C=0, and set Z from the result.
- R5: Op 8 (increment) and op 9 (decrement) act on acc. Z follows the result and H is the nibble carry or borrow. N is 0 for op 8 and 1 for op 9, and C is kept from the input.
- R6: Op 10 (complement) writes ~acc, sets N=H=1 and keeps Z and C. Op 11 (set carry) and op 12 (complement carry) do not write. They set N=H=0, keep Z, and give C=1 or C=~C respectively.
- R7: Op 13 (decimal adjust) with input N=0 adds 0x06 when H is set or the low nibble of acc exceeds 9. It adds 0x60 and sets C when C is set or acc exceeds 0x99, and otherwise C is 0. Z follows the result, H is 0 and N is kept.
- R8: Op 13 with input N=1 subtracts 0x06 when H is set and 0x60 when C is set. C and N are kept, H is 0 and Z follows the result.
- R9: Op 14 (pair add) writes pair_a+pair_b to the 16-bit result. Z is kept, N is 0, H is the carry out of bit 11 and C is the carry out of bit 15.
- R10: Op 15 (stack offset add) writes pair_a plus sign-extended opd to the 16-bit result. Z and N are 0, and H and C are the carries out of bits 3 and 7 of the unsigned add of the low byte of pair_a and opd.
- R11: Op 16 writes pair_a+1 and op 17 writes pair_a-1 to the 16-bit result, both wrapping, with all flags unchanged.
- R12: The flag input nibble is {Z,N,H,C} on bits 3..0. The output flag byte carries Z on bit 7, N on bit 6, H on bit 5 and C on bit 4, and bits 3..0 are always 0.
- R13: The 8-bit write enable is 1 only for ops 0-3, 5-10 and 13, and the 16-bit write enable only for ops 14-17. When a write enable is 0 its result equals acc or pair_a. Ops 18-31 write nothing and pass the flags through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | 8-bit operand, or signed offset for op 15 |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| pair_a_i | input | 16 | First 16-bit operand (destination pair or stack pointer) |
| pair_b_i | input | 16 | Second 16-bit operand for the pair add |
| result_o | output | 8 | 8-bit result |
| res_we_o | output | 1 | 8-bit result write enable |
| wide_o | output | 16 | 16-bit result |
| wide_we_o | output | 1 | 16-bit result write enable |
| flags_o | output | 8 | New flag byte |

## Verification
The unit is purely combinational, so every result, both write enables and the flag byte are due in the same cycle the inputs are applied, with no register in between. The bench changes the inputs just after a rising edge and samples all outputs at the following falling edge, half a period later, so the values it reads are settled. Nothing is carried from one operation to the next, so each vector is checked on its own.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int WIDE_W = 16;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;
    localparam int FLAG_W = 4;
    localparam int BCD_LIM = 9;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_CMP   = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_INC   = 5'd8,
        OP_DEC   = 5'd9,
        OP_CPL   = 5'd10,
        OP_SCF   = 5'd11,
        OP_CCF   = 5'd12,
        OP_DAA   = 5'd13,
        OP_PADD  = 5'd14,
        OP_SPOFF = 5'd15,
        OP_PINC  = 5'd16,
        OP_PDEC  = 5'd17
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              res_we;
        logic [WIDE_W-1:0] wide;
        logic              wide_we;
        flags_t            fl;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              half_o,
    output logic              full_o
);

    logic [DATA_W:0] ext_a, ext_b, ext_c, full_d;
    logic [NIB_W:0]  lo_a, lo_b, lo_c, half_d;

    always_comb begin
        ext_a = {1'b0, a_i};
        ext_b = {1'b0, b_i};
        ext_c = {{DATA_W{1'b0}}, cin_i};
        lo_a  = {1'b0, a_i[NIB_W-1:0]};
        lo_b  = {1'b0, b_i[NIB_W-1:0]};
        lo_c  = {{NIB_W{1'b0}}, cin_i};
        if (sub_i) begin
            full_d = ext_a - ext_b - ext_c;
            half_d = lo_a - lo_b - lo_c;
        end else begin
            full_d = ext_a + ext_b + ext_c;
            half_d = lo_a + lo_b + lo_c;
        end
    end

    assign sum_o  = full_d[DATA_W-1:0];
    assign full_o = full_d[DATA_W];
    assign half_o = half_d[NIB_W];

    // R2
    always_comb begin
        if (sub_i && !cin_i) begin
            sub_borrow_chk: assert (full_o == (b_i > a_i));
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              half_o
);

    logic [DATA_W-1:0] res_d;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_d = a_i & b_i;
            OP_OR:   res_d = a_i | b_i;
            OP_XOR:  res_d = a_i ^ b_i;
            OP_CPL:  res_d = ~a_i;
            default: res_d = a_i;
        endcase
    end

    assign res_o  = res_d;
    assign half_o = (op_i == OP_AND);

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  flags_t            fl_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);

    localparam logic [DATA_W-1:0] LO_FIX  = DATA_W'(6);
    localparam logic [DATA_W-1:0] HI_FIX  = DATA_W'(6) << NIB_W;
    localparam logic [DATA_W-1:0] TOP_LIM = DATA_W'((BCD_LIM << NIB_W) | BCD_LIM);

    logic [DATA_W-1:0] adj_d, res_d;
    logic              c_d;

    always_comb begin
        adj_d = '0;
        c_d   = fl_i.c;
        if (!fl_i.n) begin
            if (fl_i.h || (a_i[NIB_W-1:0] > NIB_W'(BCD_LIM))) adj_d = adj_d | LO_FIX;
            if (fl_i.c || (a_i > TOP_LIM)) begin
                adj_d = adj_d | HI_FIX;
                c_d   = 1'b1;
            end
            res_d = a_i + adj_d;
        end else begin
            if (fl_i.h) adj_d = adj_d | LO_FIX;
            if (fl_i.c) adj_d = adj_d | HI_FIX;
            res_d = a_i - adj_d;
        end
    end

    assign res_o = res_d;
    assign c_o   = c_d;

    // R8
    always_comb begin
        if (fl_i.n) begin
            daa_sub_carry_keep_chk: assert (c_o == fl_i.c);
        end
    end

endmodule

// File: rtl/alu8_wide.sv
module alu8_wide
    import alu8_pkg::*;
(
    input  op_e               op_i,
    input  logic [WIDE_W-1:0] pa_i,
    input  logic [WIDE_W-1:0] pb_i,
    input  logic [DATA_W-1:0] off_i,
    output logic [WIDE_W-1:0] res_o,
    output logic              half_o,
    output logic              full_o
);

    localparam int HB_W = WIDE_W - NIB_W;

    logic [WIDE_W:0]   pair_sum;
    logic [HB_W:0]     pair_half;
    logic [WIDE_W-1:0] off_ext;
    logic [DATA_W:0]   low_sum;
    logic [NIB_W:0]    low_half;
    logic [WIDE_W-1:0] res_d;
    logic              half_d, full_d;

    always_comb begin
        pair_sum  = {1'b0, pa_i} + {1'b0, pb_i};
        pair_half = {1'b0, pa_i[HB_W-1:0]} + {1'b0, pb_i[HB_W-1:0]};
        off_ext   = {{(WIDE_W-DATA_W){off_i[DATA_W-1]}}, off_i};
        low_sum   = {1'b0, pa_i[DATA_W-1:0]} + {1'b0, off_i};
        low_half  = {1'b0, pa_i[NIB_W-1:0]} + {1'b0, off_i[NIB_W-1:0]};
        res_d  = pa_i;
        half_d = 1'b0;
        full_d = 1'b0;
        unique case (op_i)
            OP_PADD: begin
                res_d  = pair_sum[WIDE_W-1:0];
                half_d = pair_half[HB_W];
                full_d = pair_sum[WIDE_W];
            end
            OP_SPOFF: begin
                res_d  = pa_i + off_ext;
                half_d = low_half[NIB_W];
                full_d = low_sum[DATA_W];
            end
            OP_PINC: res_d = pa_i + WIDE_W'(1);
            OP_PDEC: res_d = pa_i - WIDE_W'(1);
            default: res_d = pa_i;
        endcase
    end

    assign res_o  = res_d;
    assign half_o = half_d;
    assign full_o = full_d;

    // R11
    always_comb begin
        if (op_i == OP_PINC) begin
            pair_inc_step_chk: assert (WIDE_W'(res_o - pa_i) == WIDE_W'(1));
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opd_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [WIDE_W-1:0] pair_a_i,
    input  logic [WIDE_W-1:0] pair_b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              res_we_o,
    output logic [WIDE_W-1:0] wide_o,
    output logic              wide_we_o,
    output logic [DATA_W-1:0] flags_o
);

    op_e    op;
    flags_t fin;

    assign op  = op_e'(op_i);
    assign fin = flags_t'(flags_i);

    logic              as_sub, as_cin;
    logic [DATA_W-1:0] as_b, as_sum;
    logic              as_half, as_full;
    logic [DATA_W-1:0] lg_res;
    logic              lg_half;
    logic [DATA_W-1:0] da_res;
    logic              da_c;
    logic [WIDE_W-1:0] wd_res;
    logic              wd_half, wd_full;

    always_comb begin
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) && fin.c;
        as_b   = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : opd_i;
    end

    alu8_addsub u_addsub (
        .a_i    (acc_i),
        .b_i    (as_b),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .half_o (as_half),
        .full_o (as_full)
    );

    alu8_logic u_logic (
        .op_i   (op),
        .a_i    (acc_i),
        .b_i    (opd_i),
        .res_o  (lg_res),
        .half_o (lg_half)
    );

    alu8_daa u_daa (
        .a_i   (acc_i),
        .fl_i  (fin),
        .res_o (da_res),
        .c_o   (da_c)
    );

    alu8_wide u_wide (
        .op_i   (op),
        .pa_i   (pair_a_i),
        .pb_i   (pair_b_i),
        .off_i  (opd_i),
        .res_o  (wd_res),
        .half_o (wd_half),
        .full_o (wd_full)
    );

    alu_out_t out_d;

    always_comb begin
        out_d.res     = acc_i;
        out_d.res_we  = 1'b0;
        out_d.wide    = pair_a_i;
        out_d.wide_we = 1'b0;
        out_d.fl      = fin;
        unique case (op)
            OP_ADD, OP_ADC: begin
                out_d.res    = as_sum;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: (as_sum == '0), n: 1'b0, h: as_half, c: as_full};
            end
            OP_SUB, OP_SBC: begin
                out_d.res    = as_sum;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: (as_sum == '0), n: 1'b1, h: as_half, c: as_full};
            end
            OP_CMP: begin
                out_d.fl = '{z: (as_sum == '0), n: 1'b1, h: as_half, c: as_full};
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res    = lg_res;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: (lg_res == '0), n: 1'b0, h: lg_half, c: 1'b0};
            end
            OP_INC, OP_DEC: begin
                out_d.res    = as_sum;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: (as_sum == '0), n: (op == OP_DEC), h: as_half, c: fin.c};
            end
            OP_CPL: begin
                out_d.res    = lg_res;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
            end
            OP_SCF: out_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
            OP_CCF: out_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
            OP_DAA: begin
                out_d.res    = da_res;
                out_d.res_we = 1'b1;
                out_d.fl     = '{z: (da_res == '0), n: fin.n, h: 1'b0, c: da_c};
            end
            OP_PADD: begin
                out_d.wide    = wd_res;
                out_d.wide_we = 1'b1;
                out_d.fl      = '{z: fin.z, n: 1'b0, h: wd_half, c: wd_full};
            end
            OP_SPOFF: begin
                out_d.wide    = wd_res;
                out_d.wide_we = 1'b1;
                out_d.fl      = '{z: 1'b0, n: 1'b0, h: wd_half, c: wd_full};
            end
            OP_PINC, OP_PDEC: begin
                out_d.wide    = wd_res;
                out_d.wide_we = 1'b1;
            end
            default: ;
        endcase
    end

    assign result_o  = out_d.res;
    assign res_we_o  = out_d.res_we;
    assign wide_o    = out_d.wide;
    assign wide_we_o = out_d.wide_we;
    assign flags_o   = {out_d.fl, {(DATA_W-FLAG_W){1'b0}}};

    always_comb begin
        // R13
        one_writer_chk: assert (!(res_we_o && wide_we_o));
        // R3
        if (op == OP_CMP) begin
            cmp_no_write_chk: assert (!res_we_o && (result_o == acc_i)
                                      && (flags_o[7] == (acc_i == opd_i))
                                      && (flags_o[4] == (opd_i > acc_i)));
        end
        // R5
        if ((op == OP_INC) || (op == OP_DEC)) begin
            incdec_carry_keep_chk: assert (flags_o[4] == flags_i[0]);
        end
        // R4
        if ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR)) begin
            logic_carry_clear_chk: assert (!flags_o[4] && !flags_o[6]);
        end
        // R9
        if (op == OP_PADD) begin
            pair_add_z_keep_chk: assert (flags_o[7] == flags_i[3]);
        end
        // R10
        if (op == OP_SPOFF) begin
            spoff_zn_clear_chk: assert (!flags_o[7] && !flags_o[6]);
        end
        // R11
        if ((op == OP_PINC) || (op == OP_PDEC)) begin
            pair_step_flags_chk: assert (flags_o[7:4] == flags_i);
        end
    end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  op_i;
    logic [7:0]  acc_i, opd_i, result_o, flags_o;
    logic [3:0]  flags_i;
    logic [15:0] pair_a_i, pair_b_i, wide_o;
    logic        res_we_o, wide_we_o;

    alu8_core u_alu8_core (
        .op_i      (op_i),
        .acc_i     (acc_i),
        .opd_i     (opd_i),
        .flags_i   (flags_i),
        .pair_a_i  (pair_a_i),
        .pair_b_i  (pair_b_i),
        .result_o  (result_o),
        .res_we_o  (res_we_o),
        .wide_o    (wide_o),
        .wide_we_o (wide_we_o),
        .flags_o   (flags_o)
    );

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [7:0] acc, input logic [7:0] opd,
                         input logic [3:0] fin, input logic [15:0] pa, input logic [15:0] pb);
        @(posedge clk);
        #1;
        op_i = op; acc_i = acc; opd_i = opd; flags_i = fin;
        pair_a_i = pa; pair_b_i = pb;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [4:0] op, input logic [3:0] fin);
        case (op)
            5'd0, 5'd1:             return "R1";
            5'd2, 5'd3:             return "R2";
            5'd4:                   return "R3";
            5'd5, 5'd6, 5'd7:       return "R4";
            5'd8, 5'd9:             return "R5";
            5'd10, 5'd11, 5'd12:    return "R6";
            5'd13:                  return fin[2] ? "R8" : "R7";
            default:                return "R13";
        endcase
    endfunction

    // {op, acc, opd, flags_in, exp_result, exp_we, exp_flags}
    localparam int NVEC = 28;
    localparam logic [37:0] VEC [NVEC] = '{
        {5'd0,  8'h3A, 8'hC6, 4'h0, 8'h00, 1'b1, 4'hB},  // R1 zero with both carries
        {5'd0,  8'h0F, 8'h01, 4'h0, 8'h10, 1'b1, 4'h2},  // R1 nibble carry
        {5'd1,  8'hE1, 8'h0F, 4'h1, 8'hF1, 1'b1, 4'h2},  // R1 carry-in used
        {5'd2,  8'h3E, 8'h3E, 4'h0, 8'h00, 1'b1, 4'hC},  // R2 equal
        {5'd2,  8'h3E, 8'h0F, 4'h0, 8'h2F, 1'b1, 4'h6},  // R2 nibble borrow
        {5'd2,  8'h3E, 8'h40, 4'h0, 8'hFE, 1'b1, 4'h5},  // R2 full borrow
        {5'd3,  8'h3B, 8'h2A, 4'h1, 8'h10, 1'b1, 4'h4},  // R2 borrow-in
        {5'd3,  8'h10, 8'h0F, 4'h1, 8'h00, 1'b1, 4'hE},  // R2 borrow-in to zero
        {5'd4,  8'h3C, 8'h2F, 4'h0, 8'h3C, 1'b0, 4'h6},  // R3 compare smaller
        {5'd4,  8'h3C, 8'h3C, 4'h0, 8'h3C, 1'b0, 4'hC},  // R3 compare equal
        {5'd5,  8'h5A, 8'h3F, 4'hF, 8'h1A, 1'b1, 4'h2},  // R4 and
        {5'd5,  8'h5A, 8'hA5, 4'h0, 8'h00, 1'b1, 4'hA},  // R4 and zero
        {5'd6,  8'h5A, 8'h00, 4'hF, 8'h5A, 1'b1, 4'h0},  // R4 or
        {5'd7,  8'hFF, 8'hFF, 4'h0, 8'h00, 1'b1, 4'h8},  // R4 xor zero
        {5'd8,  8'hFF, 8'h00, 4'h1, 8'h00, 1'b1, 4'hB},  // R5 inc wrap keeps C
        {5'd8,  8'h50, 8'h00, 4'h0, 8'h51, 1'b1, 4'h0},  // R5 inc plain
        {5'd9,  8'h01, 8'h00, 4'h0, 8'h00, 1'b1, 4'hC},  // R5 dec to zero
        {5'd9,  8'h10, 8'h00, 4'h1, 8'h0F, 1'b1, 4'h7},  // R5 dec nibble borrow
        {5'd10, 8'h35, 8'h00, 4'h9, 8'hCA, 1'b1, 4'hF},  // R6 complement
        {5'd11, 8'h35, 8'h00, 4'hE, 8'h35, 1'b0, 4'h9},  // R6 set carry
        {5'd12, 8'h44, 8'h00, 4'hB, 8'h44, 1'b0, 4'h8},  // R6 complement carry
        {5'd13, 8'h7D, 8'h00, 4'h0, 8'h83, 1'b1, 4'h0},  // R7 low fix
        {5'd13, 8'h9A, 8'h00, 4'h0, 8'h00, 1'b1, 4'h9},  // R7 both fixes
        {5'd13, 8'h12, 8'h00, 4'h2, 8'h18, 1'b1, 4'h0},  // R7 H forces low fix
        {5'd13, 8'h20, 8'h00, 4'h1, 8'h80, 1'b1, 4'h1},  // R7 C forces high fix
        {5'd13, 8'h0F, 8'h00, 4'h6, 8'h09, 1'b1, 4'h4},  // R8 low fix
        {5'd13, 8'hF0, 8'h00, 4'h5, 8'h90, 1'b1, 4'h5},  // R8 high fix
        {5'd20, 8'h12, 8'h34, 4'hA, 8'h12, 1'b0, 4'hA}   // R13 unused code
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        op_i = '0; acc_i = '0; opd_i = '0; flags_i = '0; pair_a_i = '0; pair_b_i = '0;

        // initial state: add of zeros
        drive(5'd0, 8'h00, 8'h00, 4'h0, 16'h0000, 16'h0000);
        chk("R1", "zero add result", {24'b0, result_o}, 32'h00);
        chk("R12", "zero add flags", {24'b0, flags_o}, 32'h80);

        for (int i = 0; i < NVEC; i++) begin
            logic [37:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[37:33], v[16:13]);
            drive(v[37:33], v[32:25], v[24:17], v[16:13], 16'h1234, 16'h5678);
            chk(t, "result", {24'b0, result_o}, {24'b0, v[12:5]});
            chk(t, "res_we", {31'b0, res_we_o}, {31'b0, v[4]});
            chk(t, "flags", {28'b0, flags_o[7:4]}, {28'b0, v[3:0]});
            chk("R12", "flag low bits", {28'b0, flags_o[3:0]}, 32'h0);
            chk("R13", "wide pass", {16'b0, wide_o}, 32'h1234);
            chk("R13", "wide_we", {31'b0, wide_we_o}, 32'h0);
        end

        // R9 pair add, bit 11 carry, Z kept
        drive(5'd14, 8'h77, 8'h00, 4'h8, 16'h0FFF, 16'h0001);
        chk("R9", "pair sum", {16'b0, wide_o}, 32'h1000);
        chk("R9", "pair flags", {24'b0, flags_o}, 32'hA0);
        chk("R13", "pair wide_we", {31'b0, wide_we_o}, 32'h1);
        chk("R13", "pair res_we", {31'b0, res_we_o}, 32'h0);
        chk("R13", "pair result pass", {24'b0, result_o}, 32'h77);
        // R9 carry out of bit 15, zero result leaves Z clear
        drive(5'd14, 8'h00, 8'h00, 4'h0, 16'h8000, 16'h8000);
        chk("R9", "pair wrap", {16'b0, wide_o}, 32'h0000);
        chk("R9", "pair wrap flags", {24'b0, flags_o}, 32'h10);

        // R10 stack offset add, positive offset, low-byte carries
        drive(5'd15, 8'h00, 8'h08, 4'hC, 16'hFFF8, 16'h0000);
        chk("R10", "spoff sum", {16'b0, wide_o}, 32'h0000);
        chk("R10", "spoff flags", {24'b0, flags_o}, 32'h30);
        // R10 negative offset, no low-byte carry
        drive(5'd15, 8'h00, 8'hFF, 4'hF, 16'h1000, 16'h0000);
        chk("R10", "spoff neg sum", {16'b0, wide_o}, 32'h0FFF);
        chk("R10", "spoff neg flags", {24'b0, flags_o}, 32'h30 & 32'h00);

        // R11 increment and decrement wrap, flags unchanged
        drive(5'd16, 8'h00, 8'h00, 4'hA, 16'hFFFF, 16'h0000);
        chk("R11", "pinc wrap", {16'b0, wide_o}, 32'h0000);
        chk("R11", "pinc flags", {24'b0, flags_o}, 32'hA0);
        drive(5'd17, 8'h00, 8'h00, 4'h5, 16'h0000, 16'h0000);
        chk("R11", "pdec wrap", {16'b0, wide_o}, 32'hFFFF);
        chk("R11", "pdec flags", {24'b0, flags_o}, 32'h50);
        chk("R11", "pdec wide_we", {31'b0, wide_we_o}, 32'h1);

        // R13 top unused code leaves everything alone
        drive(5'd31, 8'h9C, 8'h11, 4'h3, 16'hBEEF, 16'h0101);
        chk("R13", "op31 result", {24'b0, result_o}, 32'h9C);
        chk("R13", "op31 wide", {16'b0, wide_o}, 32'hBEEF);
        chk("R13", "op31 enables", {30'b0, res_we_o, wide_we_o}, 32'h0);
        chk("R13", "op31 flags", {24'b0, flags_o}, 32'h30);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule